// File: doc/BRIEF.md
# Clock Generator Frequency Select and Output Control

This block is the control logic that sits beside the PLL of a PC clock generator. Just after power-up, several clock output pins work as strap inputs. The block samples them once, then releases the pins so they can drive clocks. From then on it picks the active frequency table index from one of two sources: the sampled straps or a software override held in a control register. It also drives one enable line per clock output, a global tristate line and the two spread-spectrum controls.

A new frequency index does not take effect at once. The block waits through a settle interval, counted in clock cycles, so that the synthesizer can move smoothly to the new frequency. A busy flag stays high for the whole interval. An active-low power-down pin stops every output. It does not change the stored enables, so the outputs come back exactly as they were when the pin is released.

Top module: `clkgen_ctrl`

## Requirements
- R1: The straps are captured once, at the first clock edge after `por_n` is released, and are held until `por_n` is asserted again. `strap_rb_n` reports them inverted: bit 4 is the 3V66 select strap and bits 3:0 are FS3..FS0.
- R2: Until that capture edge, `pins_drive` is 0 and `out_en` is all zeros. From the capture edge on, `pins_drive` is 1.
- R3: When `ctl0` bit 3 is 0, the selected index is {`strap_sel66`, FS3, FS2, FS1, FS0} taken from the captured straps, with bit 4 as the most significant bit.
- R4: When `ctl0` bit 3 is 1, the selected index is {`sw_sel66`, `ctl0`[2], `ctl0`[6:4]}. Here `ctl0`[2] is FS3 and `ctl0`[6:4] are FS2..FS0.
- R5: At the capture edge, `freq_idx` loads the selected index directly. `freq_busy` stays 0 at that edge.
- R6: A change of the selected index raises `freq_busy` after the next clock edge. `freq_idx` takes the new value SETTLE_CYC+1 edges after the change, and `freq_busy` falls at that same edge. `freq_idx` holds its value at all other times.
- R7: If the selected index changes again while `freq_busy` is high, the interval restarts with the newest index. The earlier pending index never appears on `freq_idx`.
- R8: `tristate_all` follows `ctl0` bit 0, where 1 means all outputs tristated.
- R9: `spread_on` follows `ctl0` bit 1. `spread_down` follows `ctl0` bit 7, where 0 selects center spread and 1 selects down spread.
- R10: The per-output enable register resets to all ones on `por_n` and is loaded from `en_wdata` on an edge where `en_we` is high. Bit value 1 means the output runs.
- R11: While `pd_n` is 0, `out_en` is all zeros. The enable register keeps its contents, and they reappear on `out_en` when `pd_n` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| por_n | input | 1 | Power-up reset, active low, asynchronous |
| pd_n | input | 1 | Power-down, active low |
| strap_fs | input | 4 | Frequency strap pins, FS3..FS0 |
| strap_sel66 | input | 1 | 3V66 select strap pin |
| ctl0 | input | 8 | Control register 0 fields |
| sw_sel66 | input | 1 | Software 3V66 select bit |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | N_OUT | Enable register write data |
| freq_idx | output | 5 | Active frequency table index |
| freq_busy | output | 1 | Settle interval in progress |
| out_en | output | N_OUT | Per-output enable, 1 = running |
| pins_drive | output | 1 | Dual-use pins switched to clock driving |
| tristate_all | output | 1 | Tristate all outputs |
| spread_on | output | 1 | Spread-spectrum modulation enabled |
| spread_down | output | 1 | Spread type, 1 = down spread |
| strap_rb_n | output | 5 | Inverted captured straps |

## Verification
The hardest state to reach from the ports is an index change that arrives in the middle of a settle interval. The bench changes `ctl0` a second time exactly two edges after busy rises. It then confirms that the first pending index never shows up and that the full interval restarts. Single-capture behaviour of the straps is also hard to see, because the strap pins look like ordinary inputs. The bench therefore moves them after the capture edge, and again across a second power-up, and compares the readback and the hardware-selected index in both cases.

// File: rtl/clkgen_ctrl_pkg.sv
package clkgen_ctrl_pkg;

  localparam int CODE_W = 5;
  localparam int FS_W   = 4;

  localparam int B_TRI     = 0;
  localparam int B_SPREAD  = 1;
  localparam int B_SWFS3   = 2;
  localparam int B_SRC     = 3;
  localparam int B_SWFS_LO = 4;
  localparam int B_SPTYPE  = 7;

  typedef logic [CODE_W-1:0] fcode_t;

  typedef struct packed {
    logic sw_src;
    logic tri_all;
    logic spread_on;
    logic spread_down;
  } ctl_fields_t;

  function automatic fcode_t hw_code(input logic sel66, input logic [FS_W-1:0] fs);
    return {sel66, fs};
  endfunction

  function automatic fcode_t sw_code(input logic [7:0] ctl, input logic sel66);
    return {sel66, ctl[B_SWFS3], ctl[B_SWFS_LO+2:B_SWFS_LO]};
  endfunction

  function automatic ctl_fields_t decode_ctl(input logic [7:0] ctl);
    ctl_fields_t f;
    f.sw_src      = ctl[B_SRC];
    f.tri_all     = ctl[B_TRI];
    f.spread_on   = ctl[B_SPREAD];
    f.spread_down = ctl[B_SPTYPE];
    return f;
  endfunction

endpackage

// File: rtl/clkgen_strap_latch.sv
module clkgen_strap_latch
  import clkgen_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            por_n,
  input  logic [FS_W-1:0] strap_fs,
  input  logic            strap_sel66,
  output logic            done,
  output logic            sample_pulse,
  output fcode_t          held_code
);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      done      <= 1'b0;
      held_code <= '0;
    end else if (!done) begin
      done      <= 1'b1;
      held_code <= hw_code(strap_sel66, strap_fs);
    end
  end

  assign sample_pulse = !done;

endmodule

// File: rtl/clkgen_freq_settle.sv
module clkgen_freq_settle
  import clkgen_ctrl_pkg::*;
#(
  parameter int SETTLE_CYC = 300000
) (
  input  logic   clk,
  input  logic   por_n,
  input  logic   load,
  input  fcode_t load_code,
  input  logic   active,
  input  fcode_t target,
  output fcode_t applied,
  output logic   busy,
  output logic   fire
);

  localparam int CNT_W = $clog2(SETTLE_CYC + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(SETTLE_CYC - 1);

  fcode_t           pending;
  logic [CNT_W-1:0] cnt;
  logic             retarget;
  logic             start;

  assign retarget = busy && (target != pending);
  assign fire     = busy && !retarget && (cnt == '0);
  assign start    = active && !busy && (target != applied);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      applied <= '0;
      pending <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
    end else if (load) begin
      applied <= load_code;
      pending <= load_code;
      cnt     <= '0;
      busy    <= 1'b0;
    end else if (active) begin
      if (retarget) begin
        pending <= target;
        cnt     <= RELOAD;
      end else if (fire) begin
        applied <= pending;
        busy    <= 1'b0;
      end else if (busy) begin
        cnt <= cnt - 1'b1;
      end else if (start) begin
        pending <= target;
        cnt     <= RELOAD;
        busy    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/clkgen_out_gate.sv
module clkgen_out_gate #(
  parameter int N_OUT = 25
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             en_we,
  input  logic [N_OUT-1:0] en_wdata,
  input  logic             allow,
  output logic [N_OUT-1:0] out_en
);

  logic [N_OUT-1:0] en_reg;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     en_reg <= '1;
    else if (en_we) en_reg <= en_wdata;
  end

  for (genvar i = 0; i < N_OUT; i++) begin : g_gate
    assign out_en[i] = allow & en_reg[i];
  end

endmodule

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_ctrl_pkg::*;
#(
  parameter int N_OUT      = 25,
  parameter int SETTLE_CYC = 300000
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             pd_n,
  input  logic [3:0]       strap_fs,
  input  logic             strap_sel66,
  input  logic [7:0]       ctl0,
  input  logic             sw_sel66,
  input  logic             en_we,
  input  logic [N_OUT-1:0] en_wdata,
  output logic [4:0]       freq_idx,
  output logic             freq_busy,
  output logic [N_OUT-1:0] out_en,
  output logic             pins_drive,
  output logic             tristate_all,
  output logic             spread_on,
  output logic             spread_down,
  output logic [4:0]       strap_rb_n
);

  ctl_fields_t fields;
  fcode_t      held_code;
  fcode_t      sel_code;
  fcode_t      first_code;
  fcode_t      applied;
  logic        done;
  logic        sample_pulse;
  logic        fire;

  assign fields = decode_ctl(ctl0);

  clkgen_strap_latch u_strap (
    .clk          (clk),
    .por_n        (por_n),
    .strap_fs     (strap_fs),
    .strap_sel66  (strap_sel66),
    .done         (done),
    .sample_pulse (sample_pulse),
    .held_code    (held_code)
  );

  assign sel_code   = fields.sw_src ? sw_code(ctl0, sw_sel66) : held_code;
  assign first_code = fields.sw_src ? sw_code(ctl0, sw_sel66)
                                    : hw_code(strap_sel66, strap_fs);

  clkgen_freq_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk       (clk),
    .por_n     (por_n),
    .load      (sample_pulse),
    .load_code (first_code),
    .active    (done),
    .target    (sel_code),
    .applied   (applied),
    .busy      (freq_busy),
    .fire      (fire)
  );

  clkgen_out_gate #(.N_OUT(N_OUT)) u_gate (
    .clk      (clk),
    .por_n    (por_n),
    .en_we    (en_we),
    .en_wdata (en_wdata),
    .allow    (done & pd_n),
    .out_en   (out_en)
  );

  assign freq_idx     = applied;
  assign pins_drive   = done;
  assign strap_rb_n   = ~held_code;
  assign tristate_all = fields.tri_all;
  assign spread_on    = fields.spread_on;
  assign spread_down  = fields.spread_down;

endmodule

// File: rtl/clkgen_ctrl_chk.sv
module clkgen_ctrl_chk #(
  parameter int N_OUT = 25
) (
  input logic             clk,
  input logic             por_n,
  input logic             pd_n,
  input logic [4:0]       freq_idx,
  input logic             freq_busy,
  input logic [N_OUT-1:0] out_en,
  input logic             pins_drive,
  input logic [4:0]       strap_rb_n,
  input logic             sample_pulse,
  input logic             fire
);

  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!por_n)
    (pins_drive && $past(pins_drive)) |-> $stable(strap_rb_n));

  p_no_drive_pre_r2: assert property (@(posedge clk) disable iff (!por_n)
    !pins_drive |-> (out_en == '0));

  p_first_load_r5: assert property (@(posedge clk) disable iff (!por_n)
    sample_pulse |=> (pins_drive && !freq_busy));

  p_settle_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    (freq_busy && !fire) |=> $stable(freq_idx));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    (!freq_busy && !sample_pulse) |=> $stable(freq_idx));

  p_fire_clear_r6: assert property (@(posedge clk) disable iff (!por_n)
    fire |=> !freq_busy);

  p_pd_off_r11: assert property (@(posedge clk) disable iff (!por_n)
    !pd_n |-> (out_en == '0));

endmodule

bind clkgen_ctrl clkgen_ctrl_chk #(.N_OUT(N_OUT)) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .pd_n         (pd_n),
  .freq_idx     (freq_idx),
  .freq_busy    (freq_busy),
  .out_en       (out_en),
  .pins_drive   (pins_drive),
  .strap_rb_n   (strap_rb_n),
  .sample_pulse (sample_pulse),
  .fire         (fire)
);

// File: tb/sim_clkgen_ctrl.sv
module sim_clkgen_ctrl;

  localparam int N = 25;
  localparam int S = 5;

  logic         clk = 1'b0;
  logic         por_n = 1'b0;
  logic         pd_n = 1'b1;
  logic [3:0]   strap_fs = 4'b1010;
  logic         strap_sel66 = 1'b1;
  logic [7:0]   ctl0 = 8'h00;
  logic         sw_sel66 = 1'b0;
  logic         en_we = 1'b0;
  logic [N-1:0] en_wdata = '0;
  logic [4:0]   freq_idx;
  logic         freq_busy;
  logic [N-1:0] out_en;
  logic         pins_drive, tristate_all, spread_on, spread_down;
  logic [4:0]   strap_rb_n;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  clkgen_ctrl #(.N_OUT(N), .SETTLE_CYC(S)) u0 (
    .clk(clk), .por_n(por_n), .pd_n(pd_n), .strap_fs(strap_fs),
    .strap_sel66(strap_sel66), .ctl0(ctl0), .sw_sel66(sw_sel66),
    .en_we(en_we), .en_wdata(en_wdata), .freq_idx(freq_idx),
    .freq_busy(freq_busy), .out_en(out_en), .pins_drive(pins_drive),
    .tristate_all(tristate_all), .spread_on(spread_on),
    .spread_down(spread_down), .strap_rb_n(strap_rb_n)
  );

  // {ctl0, sw_sel66, expected index}; captured straps give 5'b11010
  localparam logic [13:0] VEC [6] = '{
    {8'b0000_0000, 1'b0, 5'b11010},
    {8'b0101_1000, 1'b1, 5'b10101},
    {8'b0011_1100, 1'b0, 5'b01011},
    {8'b1000_0011, 1'b0, 5'b11010},
    {8'b1111_1110, 1'b1, 5'b11111},
    {8'b0000_1000, 1'b0, 5'b00000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic negs(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    negs(3);
    chk("R2 pins before release", 32'(pins_drive), 0);
    chk("R2 out_en in reset", 32'(out_en), 0);
    por_n = 1'b1;
    chk("R2 out_en before capture", 32'(out_en), 0);
    negs(1);
    chk("R2 pins drive after capture", 32'(pins_drive), 1);
    chk("R1 readback inverted", 32'(strap_rb_n), 32'(5'b00101));
    chk("R5 direct load", 32'(freq_idx), 32'(5'b11010));
    chk("R5 no busy at capture", 32'(freq_busy), 0);
    chk("R10 enables reset ones", 32'(out_en), 32'({N{1'b1}}));
    strap_fs = 4'b0101; strap_sel66 = 1'b0;
    negs(S + 3);
    chk("R1 readback held", 32'(strap_rb_n), 32'(5'b00101));
    chk("R3 hw index held", 32'(freq_idx), 32'(5'b11010));

    for (int i = 0; i < 6; i++) begin
      ctl0 = VEC[i][13:6]; sw_sel66 = VEC[i][5];
      negs(S + 3);
      chk(ctl0[3] ? "R4 sw index" : "R3 hw index", 32'(freq_idx), 32'(VEC[i][4:0]));
      chk("R8 tristate", 32'(tristate_all), 32'(VEC[i][6]));
      chk("R9 spread on", 32'(spread_on), 32'(VEC[i][7]));
      chk("R9 spread type", 32'(spread_down), 32'(VEC[i][13]));
    end

    // R6 timing: current index 00000 in sw mode
    ctl0 = 8'b0111_1000;
    negs(1);
    chk("R6 busy rises", 32'(freq_busy), 1);
    chk("R6 old index held", 32'(freq_idx), 0);
    negs(S - 1);
    chk("R6 index held to end", 32'(freq_idx), 0);
    chk("R6 busy still high", 32'(freq_busy), 1);
    negs(1);
    chk("R6 new index", 32'(freq_idx), 32'(5'b00111));
    chk("R6 busy falls", 32'(freq_busy), 0);

    // R7 restart during busy
    ctl0 = 8'b0001_1000;
    negs(3);
    ctl0 = 8'b0010_1100;
    negs(S);
    chk("R7 first pending skipped", 32'(freq_idx), 32'(5'b00111));
    chk("R7 busy after restart", 32'(freq_busy), 1);
    negs(1);
    chk("R7 newest index", 32'(freq_idx), 32'(5'b01010));

    // R10 / R11 enables and power-down
    en_wdata = 25'h0A5_A5A5; en_we = 1'b1;
    negs(1);
    en_we = 1'b0;
    chk("R10 enable write", 32'(out_en), 32'h0A5_A5A5);
    pd_n = 1'b0;
    negs(1);
    chk("R11 power-down stops all", 32'(out_en), 0);
    pd_n = 1'b1;
    negs(1);
    chk("R11 enables restored", 32'(out_en), 32'h0A5_A5A5);

    // second power-up recaptures the straps
    ctl0 = 8'h00;
    por_n = 1'b0;
    negs(2);
    por_n = 1'b1;
    negs(1);
    chk("R1 recapture readback", 32'(strap_rb_n), 32'(5'b11010));
    chk("R3 hw index after recapture", 32'(freq_idx), 32'(5'b00101));
    chk("R10 enables reset again", 32'(out_en), 32'({N{1'b1}}));

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule